// File: doc/BRIEF.md
# Driver Fault Supervisor

This block gathers the digital fault indications of a full-bridge gate driver into one active-low fault flag, one global gate-disable signal and a sleep indication. It watches three supply and temperature levels: the logic supply, the gate regulator and the die temperature. It also watches one bootstrap charge-timeout line per bridge phase. Each level goes through a hysteresis comparator, and a parameter selects the comparator variant. In the raw variant a level code is compared against thresholds supplied on ports. In the digital variant bit 0 of the level input is already a hysteresis-qualified fault bit.

The bootstrap timeouts are sticky. They are released only by the supervisor's own reset-pin handling or by a logic-supply undervoltage. A logic-supply undervoltage overrides every other fault state. Overtemperature only pulls the flag low and never blocks the gates.

The active-low reset request pin is synchronized, and a state machine measures how long it stays low. A pulse of at least `PULSE_CYC` synchronized cycles clears the sticky faults. A hold of `SLEEP_CYC` cycles puts the block to sleep. After sleep, and after power-up, a settle timer of `HOLD_CYC` cycles keeps the gates disabled while the charge pump stabilizes.

The states are:
- ST_RUN: normal operation.
- ST_HOLDLOW: the request pin is low and is being timed.
- ST_SLEEP: the block is asleep.
- ST_WAKE: the settle timer is running. This is also the state after `por_n`.

The transitions are:
- RUN to HOLDLOW when the synchronized request goes low.
- HOLDLOW to RUN when it returns high.
- HOLDLOW to SLEEP after `SLEEP_CYC` low cycles.
- SLEEP to WAKE when the request goes high.
- WAKE to RUN after `HOLD_CYC` cycles.
- WAKE to HOLDLOW when the request goes low.

Top module: `fault_supervisor`

## Requirements
- R1: `fault_n` is 1 only when no fault of any kind is active, or while the block is asleep. Otherwise it is 0.
- R2: The overtemperature state sets when `temp_lvl` > `temp_trip_thr`. It clears when `temp_lvl` < `temp_trip_thr` − `temp_hyst`. It pulls `fault_n` low, does not assert `drive_dis`, and is not latched.
- R3: The regulator undervoltage state sets when `vreg_lvl` < `vreg_fall_thr` and clears when `vreg_lvl` > `vreg_rise_thr`. It is active from power-up, pulls `fault_n` low, asserts `drive_dis` and is not latched.
- R4: The logic-supply undervoltage state sets when `vdd_lvl` < `vdd_fall_thr` and clears when `vdd_lvl` > `vdd_fall_thr` + `vdd_hyst`. It is active from power-up, pulls `fault_n` low and asserts `drive_dis`.
- R5: While the logic-supply undervoltage state is active, every sticky bootstrap fault is cleared and none can be set. After the supply recovers, no earlier bootstrap fault remains.
- R6: A 1 on `boot_tmo[i]` for one clock sets a sticky bootstrap fault for phase i. The fault keeps `fault_n` low and `drive_dis` high after the input drops.
- R7: A low on `rst_req_n` lasting at least `PULSE_CYC` synchronized cycles clears the sticky bootstrap faults without sleep. A shorter low leaves them set.
- R8: A low on `rst_req_n` lasting `SLEEP_CYC` synchronized cycles enters sleep, where `sleep` = 1, `drive_dis` = 1 and `fault_n` = 1.
- R9: After power-up and after leaving sleep, `drive_dis` stays 1 for `HOLD_CYC` cycles, then follows the faults.
- R10: While the synchronized `rst_req_n` is low, `drive_dis` is 1.
- R11: A level change is seen on the outputs after the first clock edge that samples it. A `rst_req_n` change is seen three edges after it, through two synchronizer stages and the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_req_n | input | 1 | Active-low reset/sleep request pin |
| vdd_lvl | input | LVL_W | Logic-supply level code (bit 0 = fault bit in digital variant) |
| vreg_lvl | input | LVL_W | Gate-regulator level code |
| temp_lvl | input | LVL_W | Die temperature code |
| vdd_fall_thr | input | LVL_W | Logic-supply falling threshold |
| vdd_hyst | input | LVL_W | Logic-supply hysteresis |
| vreg_fall_thr | input | LVL_W | Regulator falling threshold |
| vreg_rise_thr | input | LVL_W | Regulator rising threshold |
| temp_trip_thr | input | LVL_W | Overtemperature trip code |
| temp_hyst | input | LVL_W | Overtemperature hysteresis |
| boot_tmo | input | NPH | Per-phase bootstrap charge timeout |
| fault_n | output | 1 | Combined fault flag, active low |
| drive_dis | output | 1 | Global gate-drive disable |
| sleep | output | 1 | Sleep indication |

## Verification
The interesting collision is a bootstrap timeout in the same cycle as a logic-supply undervoltage, or while one is active. The undervoltage must win and leave no sticky fault behind once the supply recovers. The bench provokes this by asserting a timeout on the very edge where the supply code drops, and by holding it through the fault. It then checks that `fault_n` returns high when the supply recovers. A second overlap is a sticky fault meeting a reset pulse: a pulse just under and well over `PULSE_CYC` shows whether the clear fires. A cycle-accurate reference model judges every clock in all of these cases.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLDLOW = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_WAKE    = 2'd3
    } sup_state_t;
endpackage

// File: rtl/fsup_hyst.sv
module fsup_hyst #(
    parameter int   LVL_W     = 8,
    parameter bit   RAW       = 1'b1,
    parameter bit   HIGH_TRIP = 1'b0,
    parameter bit   INIT      = 1'b1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W:0]   set_thr,
    input  logic [LVL_W:0]   clr_thr,
    output logic             flag
);
    logic flag_q;
    logic flag_d;

    generate
        if (RAW) begin : g_raw
            logic [LVL_W:0] lvl_x;
            logic           beyond_set;
            logic           beyond_clr;
            assign lvl_x = {1'b0, lvl};
            if (HIGH_TRIP) begin : g_high
                assign beyond_set = lvl_x > set_thr;
                assign beyond_clr = lvl_x < clr_thr;
            end else begin : g_low
                assign beyond_set = lvl_x < set_thr;
                assign beyond_clr = lvl_x > clr_thr;
            end
            always_comb begin
                if (flag_q) flag_d = !beyond_clr;
                else        flag_d = beyond_set;
            end
        end else begin : g_dig
            logic unused_thr;
            assign unused_thr = ^{set_thr, clr_thr, lvl[LVL_W-1:1]};
            assign flag_d = lvl[0];
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= INIT;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/fsup_boot_latch.sv
module fsup_boot_latch #(
    parameter int NPH = 2
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic [NPH-1:0] boot_tmo,
    input  logic           clr_i,
    input  logic           block_i,
    output logic [NPH-1:0] lat_o
);
    generate
        for (genvar p = 0; p < NPH; p++) begin : g_ph
            logic lat_q;
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)      lat_q <= 1'b0;
                else if (clr_i)  lat_q <= 1'b0;
                else if (boot_tmo[p] && !block_i) lat_q <= 1'b1;
            end
            assign lat_o[p] = lat_q;

            AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
                (lat_q && !clr_i) |=> lat_q); // R6
        end
    endgenerate

    AST_SUPPLY_WIPES_LATCH: assert property (@(posedge clk) disable iff (!por_n)
        block_i |=> (lat_o == '0)); // R5
endmodule

// File: rtl/fsup_rst_ctl.sv
module fsup_rst_ctl
    import fsup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CYC   = 8,
    parameter int SLEEP_CYC   = 40,
    parameter int HOLD_CYC    = 150
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_req_n,
    output logic clr_lat_o,
    output logic sleep_o,
    output logic hold_dis_o
);
    localparam int CNT_MAX = (SLEEP_CYC > HOLD_CYC) ? SLEEP_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rq_s;
    sup_state_t             st_q, st_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rst_req_n};
    end
    assign rq_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= ST_WAKE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (!rq_s) begin
                    st_d  = ST_HOLDLOW;
                    cnt_d = CNT_W'(1);
                end
            end
            ST_HOLDLOW: begin
                if (rq_s) begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end else if (cnt_q == CNT_W'(SLEEP_CYC - 1)) begin
                    st_d  = ST_SLEEP;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SLEEP: begin
                if (rq_s) begin
                    st_d  = ST_WAKE;
                    cnt_d = '0;
                end
            end
            ST_WAKE: begin
                if (!rq_s) begin
                    st_d  = ST_HOLDLOW;
                    cnt_d = CNT_W'(1);
                end else if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = ST_WAKE;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        clr_lat_o  = 1'b0;
        sleep_o    = 1'b0;
        hold_dis_o = 1'b1;
        unique case (st_q)
            ST_RUN:     hold_dis_o = 1'b0;
            ST_HOLDLOW: clr_lat_o  = (cnt_q >= CNT_W'(PULSE_CYC));
            ST_SLEEP: begin
                clr_lat_o = 1'b1;
                sleep_o   = 1'b1;
            end
            ST_WAKE:    hold_dis_o = 1'b1;
            default:    hold_dis_o = 1'b1;
        endcase
    end

    AST_SLEEP_AFTER_FULL_LOW: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sleep_o) |-> ($past(cnt_q) == CNT_W'(SLEEP_CYC - 1))); // R8
    AST_WAKE_KEEPS_DISABLE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sleep_o) |-> hold_dis_o); // R9
    AST_LOW_REQ_DISABLES: assert property (@(posedge clk) disable iff (!por_n)
        !rq_s |=> hold_dis_o); // R10
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
    parameter int LVL_W       = 8,
    parameter int NPH         = 2,
    parameter bit RAW_MODE    = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CYC   = 8,
    parameter int SLEEP_CYC   = 40,
    parameter int HOLD_CYC    = 150
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_req_n,
    input  logic [LVL_W-1:0] vdd_lvl,
    input  logic [LVL_W-1:0] vreg_lvl,
    input  logic [LVL_W-1:0] temp_lvl,
    input  logic [LVL_W-1:0] vdd_fall_thr,
    input  logic [LVL_W-1:0] vdd_hyst,
    input  logic [LVL_W-1:0] vreg_fall_thr,
    input  logic [LVL_W-1:0] vreg_rise_thr,
    input  logic [LVL_W-1:0] temp_trip_thr,
    input  logic [LVL_W-1:0] temp_hyst,
    input  logic [NPH-1:0]   boot_tmo,
    output logic             fault_n,
    output logic             drive_dis,
    output logic             sleep
);
    logic [LVL_W:0] vdd_set, vdd_clr, vreg_set, vreg_clr, ot_set, ot_clr;
    logic           vdd_uv, vreg_uv, ot_hot;
    logic [NPH-1:0] boot_lat;
    logic           clr_req, sleep_st, hold_dis;
    logic           any_boot, latch_clr;

    assign vdd_set  = {1'b0, vdd_fall_thr};
    assign vdd_clr  = {1'b0, vdd_fall_thr} + {1'b0, vdd_hyst};
    assign vreg_set = {1'b0, vreg_fall_thr};
    assign vreg_clr = {1'b0, vreg_rise_thr};
    assign ot_set   = {1'b0, temp_trip_thr};
    assign ot_clr   = (temp_hyst > temp_trip_thr) ? '0
                    : ({1'b0, temp_trip_thr} - {1'b0, temp_hyst});

    fsup_hyst #(.LVL_W(LVL_W), .RAW(RAW_MODE), .HIGH_TRIP(1'b0), .INIT(1'b1)) u_vdd_cmp (
        .clk(clk), .por_n(por_n), .lvl(vdd_lvl),
        .set_thr(vdd_set), .clr_thr(vdd_clr), .flag(vdd_uv)
    );

    fsup_hyst #(.LVL_W(LVL_W), .RAW(RAW_MODE), .HIGH_TRIP(1'b0), .INIT(1'b1)) u_vreg_cmp (
        .clk(clk), .por_n(por_n), .lvl(vreg_lvl),
        .set_thr(vreg_set), .clr_thr(vreg_clr), .flag(vreg_uv)
    );

    fsup_hyst #(.LVL_W(LVL_W), .RAW(RAW_MODE), .HIGH_TRIP(1'b1), .INIT(1'b0)) u_ot_cmp (
        .clk(clk), .por_n(por_n), .lvl(temp_lvl),
        .set_thr(ot_set), .clr_thr(ot_clr), .flag(ot_hot)
    );

    fsup_rst_ctl #(
        .SYNC_STAGES(SYNC_STAGES), .PULSE_CYC(PULSE_CYC),
        .SLEEP_CYC(SLEEP_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_rst_ctl (
        .clk(clk), .por_n(por_n), .rst_req_n(rst_req_n),
        .clr_lat_o(clr_req), .sleep_o(sleep_st), .hold_dis_o(hold_dis)
    );

    assign latch_clr = clr_req | vdd_uv;

    fsup_boot_latch #(.NPH(NPH)) u_boot (
        .clk(clk), .por_n(por_n), .boot_tmo(boot_tmo),
        .clr_i(latch_clr), .block_i(vdd_uv), .lat_o(boot_lat)
    );

    assign any_boot = |boot_lat;

    always_comb begin
        sleep     = sleep_st;
        drive_dis = hold_dis | vdd_uv | vreg_uv | any_boot;
        if (sleep_st) fault_n = 1'b1;
        else          fault_n = !(vdd_uv | vreg_uv | ot_hot | any_boot);
    end

    AST_BOOT_FAULT_DISABLES: assert property (@(posedge clk) disable iff (!por_n)
        any_boot |-> drive_dis); // R6
    AST_SLEEP_FLAG_RELEASED: assert property (@(posedge clk) disable iff (!por_n)
        sleep |-> (fault_n && drive_dis)); // R8
endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
    localparam int LW = 8, NP = 2, PULSE = 8, SLP = 40, HOLD = 150;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_req_n = 1'b1;
    logic [LW-1:0] vdd_lvl = '0, vreg_lvl = '0, temp_lvl = 8'd50;
    logic [LW-1:0] vdd_fall = 8'd100, vdd_hy = 8'd10;
    logic [LW-1:0] vreg_fall = 8'd70, vreg_rise = 8'd80;
    logic [LW-1:0] t_trip = 8'd170, t_hy = 8'd15;
    logic [NP-1:0] boot_tmo = '0;
    logic fault_n, drive_dis, sleep;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    fault_supervisor #(.LVL_W(LW), .NPH(NP), .PULSE_CYC(PULSE),
                       .SLEEP_CYC(SLP), .HOLD_CYC(HOLD)) i_fault_supervisor (
        .clk(clk), .por_n(por_n), .rst_req_n(rst_req_n),
        .vdd_lvl(vdd_lvl), .vreg_lvl(vreg_lvl), .temp_lvl(temp_lvl),
        .vdd_fall_thr(vdd_fall), .vdd_hyst(vdd_hy),
        .vreg_fall_thr(vreg_fall), .vreg_rise_thr(vreg_rise),
        .temp_trip_thr(t_trip), .temp_hyst(t_hy),
        .boot_tmo(boot_tmo),
        .fault_n(fault_n), .drive_dis(drive_dis), .sleep(sleep)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference: mode 0 run, 1 request low, 2 asleep, 3 settling
    bit m_s1 = 1, m_s2 = 1, m_vdd = 1, m_vreg = 1, m_ot = 0;
    bit m_boot [NP];
    int m_mode = 3, m_run = 0;

    always @(posedge clk) begin
        cyc++;
        if (!por_n) begin
            m_s1 = 1; m_s2 = 1; m_vdd = 1; m_vreg = 1; m_ot = 0;
            m_mode = 3; m_run = 0;
            foreach (m_boot[i]) m_boot[i] = 0;
        end else begin
            bit wipe;
            bit n_vdd, n_vreg, n_ot;
            wipe = m_vdd || m_mode == 2 || (m_mode == 1 && m_run >= PULSE);
            foreach (m_boot[i]) m_boot[i] = wipe ? 0 : (m_boot[i] || (boot_tmo[i] && !m_vdd));
            n_vdd = m_vdd ? !(int'(vdd_lvl) > int'(vdd_fall) + int'(vdd_hy)) : (vdd_lvl < vdd_fall);
            n_vreg = m_vreg ? !(vreg_lvl > vreg_rise) : (vreg_lvl < vreg_fall);
            n_ot = m_ot ? !(int'(temp_lvl) < int'(t_trip) - int'(t_hy)) : (temp_lvl > t_trip);
            m_vdd = n_vdd; m_vreg = n_vreg; m_ot = n_ot;
            case (m_mode)
                0: if (!m_s2) begin m_mode = 1; m_run = 1; end
                1: if (m_s2) begin m_mode = 0; m_run = 0; end
                   else if (m_run == SLP - 1) begin m_mode = 2; m_run = 0; end
                   else m_run++;
                2: if (m_s2) begin m_mode = 3; m_run = 0; end
                default: if (!m_s2) begin m_mode = 1; m_run = 1; end
                   else if (m_run == HOLD - 1) begin m_mode = 0; m_run = 0; end
                   else m_run++;
            endcase
            m_s2 = m_s1; m_s1 = rst_req_n;
        end
        #5;
        if (por_n) begin
            bit anyb;
            anyb = 0;
            foreach (m_boot[i]) anyb |= m_boot[i];
            check("R1", "model fault_n", fault_n,
                  (m_mode == 2) ? 1'b1 : !(m_vdd || m_vreg || m_ot || anyb));
            check("R9", "model drive_dis", drive_dis, (m_mode != 0) || m_vdd || m_vreg || anyb);
            check("R8", "model sleep", sleep, m_mode == 2);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        por_n = 1'b1;
        step(1);
        check("R3", "power-up fault_n", fault_n, 1'b0);
        check("R4", "power-up drive_dis", drive_dis, 1'b1);
        vdd_lvl = 8'd200; vreg_lvl = 8'd200;
        step(20);
        check("R9", "settle keeps disable", drive_dis, 1'b1);
        check("R1", "flag clear after supplies good", fault_n, 1'b1);
        step(HOLD);
        check("R9", "disable released after settle", drive_dis, 1'b0);
        // overtemperature with hysteresis
        temp_lvl = 8'd171; step(2);
        check("R2", "hot flags", fault_n, 1'b0);
        check("R2", "hot does not disable", drive_dis, 1'b0);
        temp_lvl = 8'd160; step(2);
        check("R2", "inside hysteresis", fault_n, 1'b0);
        temp_lvl = 8'd154; step(1);
        check("R11", "one edge latency", fault_n, 1'b1);
        // regulator undervoltage
        vreg_lvl = 8'd75; step(2);
        check("R3", "between thresholds", drive_dis, 1'b0);
        vreg_lvl = 8'd69; step(2);
        check("R3", "vreg low disables", drive_dis, 1'b1);
        vreg_lvl = 8'd75; step(2);
        check("R3", "vreg held in hysteresis", fault_n, 1'b0);
        vreg_lvl = 8'd81; step(2);
        check("R3", "vreg recovers, not latched", drive_dis, 1'b0);
        // bootstrap timeout latching and short reset pulse
        boot_tmo = 2'b10; step(1); boot_tmo = '0; step(3);
        check("R6", "boot sticky flag", fault_n, 1'b0);
        check("R6", "boot sticky disable", drive_dis, 1'b1);
        rst_req_n = 1'b0; step(3); rst_req_n = 1'b1; step(6);
        check("R7", "short pulse keeps latch", fault_n, 1'b0);
        rst_req_n = 1'b0; step(PULSE + 4);
        check("R7", "long pulse clears latch", fault_n, 1'b1);
        check("R10", "low request disables", drive_dis, 1'b1);
        check("R8", "no sleep below limit", sleep, 1'b0);
        rst_req_n = 1'b1; step(4);
        check("R7", "enabled after pulse", drive_dis, 1'b0);
        // supply undervoltage overriding a bootstrap fault
        boot_tmo = 2'b01; vdd_lvl = 8'd95; step(3);
        check("R4", "vdd low flags", fault_n, 1'b0);
        check("R4", "vdd low disables", drive_dis, 1'b1);
        vdd_lvl = 8'd105; step(3);
        check("R4", "vdd held in hysteresis", drive_dis, 1'b1);
        boot_tmo = '0; step(1);
        vdd_lvl = 8'd111; step(2);
        check("R5", "no boot fault after vdd recovery", fault_n, 1'b1);
        check("R5", "drives enabled after vdd recovery", drive_dis, 1'b0);
        // sleep entry and wake settle
        boot_tmo = 2'b11; step(1); boot_tmo = '0;
        rst_req_n = 1'b0; step(SLP + 5);
        check("R8", "asleep", sleep, 1'b1);
        check("R8", "sleep releases flag", fault_n, 1'b1);
        check("R8", "sleep disables", drive_dis, 1'b1);
        rst_req_n = 1'b1; step(5);
        check("R9", "awake", sleep, 1'b0);
        check("R9", "wake holds disable", drive_dis, 1'b1);
        step(HOLD - 20);
        check("R9", "still settling", drive_dis, 1'b1);
        step(30);
        check("R9", "settled", drive_dis, 1'b0);
        check("R1", "no fault after sleep", fault_n, 1'b1);
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule